// File: doc/BRIEF.md
# Packet Container Builder and Unpacker

This block packs variable-length Ethernet packets into one fixed-size word container and unpacks them again. The container is an on-chip RAM of 32-bit words. A header at the front holds a summary word and a table of packet byte lengths, and packet data follows. On the fill side the block takes a byte stream with first and last markers. It places each packet on a fresh word boundary after the header. When a packet ends it writes the packet's length into the table. A close request then writes the summary word, which holds the count of used words and the count of packets. A clear request starts a new, empty container.

On the drain side a start request makes the block walk the stored header. It fetches the summary word, then each length entry in turn. It streams every stored packet back out byte by byte with first and last markers, then returns to idle. A packet that breaks the length limits, or that does not fit, is dropped whole and leaves the container as it was.

Top module: `pkt_container`

## Requirements
- R1: After reset, inReady is 1 and containerFull, rdBusy and outValid are 0. An empty container that is closed and read back reports 0 packets and a used-word count equal to the header size, and it emits no bytes.
- R2: Packet bytes are stored little-endian: the first byte of a word goes in bits 7:0 and the fourth in bits 31:24. The first packet starts at the first word after the header, and every packet starts on a new word. The reader returns each accepted packet's bytes in order, with outFirst on the first byte and outLast on the last.
- R3: The length of packet i is kept in header word 1+i/2. An even i uses bits 31:16 and an odd i uses bits 15:0. The packet lengths seen at the reader equal the accepted lengths.
- R4: Closing writes header word 0, with bits 31:16 holding the next free word index (header included) and bits 15:0 holding the packet count. The reader shows these two fields on hdrWords and hdrPkts.
- R5: A packet whose byte length is below MIN_LEN or above MAX_LEN, and which fits in the container, is dropped. pktRejected pulses once and containerFull does not change.
- R6: A packet that starts when MAX_PKTS packets are already stored is dropped at its first byte, with one pktRejected pulse, and containerFull is set.
- R7: A packet that would need a word at index WORDS or above is dropped, with one pktRejected pulse, and containerFull is set. A packet that ends exactly in the last word is accepted.
- R8: After the last byte of an accepted packet, inReady is low for exactly one cycle while the length entry is written. After a dropped packet, inReady stays high.
- R9: clearReq empties the container, so the next close reads back 0 packets. It also clears containerFull.
- R10: The reader walks the packets in index order, ends with rdBusy low, and emits bytes only while rdBusy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearReq | input | 1 | Start a new, empty container |
| closeReq | input | 1 | Write the summary word (taken while the fill side is idle) |
| inValid | input | 1 | Input byte valid |
| inByte | input | 8 | Input byte |
| inFirst | input | 1 | Marks the first byte of a packet |
| inLast | input | 1 | Marks the last byte of a packet |
| inReady | output | 1 | A byte is taken when inValid and inReady are both high |
| pktRejected | output | 1 | One-cycle pulse when a packet is dropped |
| containerFull | output | 1 | Sticky: a packet was dropped for lack of table or word space |
| rdStart | input | 1 | Start draining the container |
| rdBusy | output | 1 | Reader active |
| outValid | output | 1 | Output byte valid |
| outByte | output | 8 | Output byte |
| outFirst | output | 1 | First byte of an output packet |
| outLast | output | 1 | Last byte of an output packet |
| hdrWords | output | 16 | Used-word field read from header word 0 |
| hdrPkts | output | 16 | Packet-count field read from header word 0 |

## Verification
A wrong write pointer or byte lane shows as shifted or misplaced bytes in the read-back stream. A wrong commit pointer shows in hdrWords as soon as the container is closed and drained. A bad table index or wrong half-word choice gives wrong outFirst and outLast positions on the packet that owns the entry. A miscounted packet count or a wrong full decision shows in the same packet's pktRejected pulse, in containerFull, or in hdrPkts on the next read. The sweeps cover every legal length and several illegal lengths. They mix back-to-back and gapped input, and they reach both the table limit and the word limit, including an exact fill.

// File: rtl/pkt_container_pkg.sv
package pkt_container_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;
    logic startPkt;
    logic takeByte;
    logic commitLen;
    logic closeWr;
    logic setFull;
    logic rdHdr;
    logic loadHdr;
    logic rdLen;
    logic loadLen;
    logic rdWord;
    logic emit;
  } ctrlStrobes_t;

  // status from datapath to control
  typedef struct packed {
    logic commitAtEnd;
    logic wrAtEnd;
    logic tableFull;
    logic lenOk;
    logic rdWordEnd;
    logic rdPktEnd;
    logic rdAllDone;
    logic rdHdrZero;
  } dpStatus_t;

endpackage

// File: rtl/pkt_container_ctrl.sv
module pkt_container_ctrl
  import pkt_container_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1538
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clearReq,
  input  logic         closeReq,
  input  logic         inValid,
  input  logic         inFirst,
  input  logic         inLast,
  input  logic         rdStart,
  input  dpStatus_t    st,
  output ctrlStrobes_t str,
  output logic         inReady,
  output logic         pktRejected,
  output logic         rdBusy
);

  localparam bit ONE_OK = (MIN_LEN <= 1) && (MAX_LEN >= 1);

  typedef enum logic [1:0] {W_IDLE, W_PKT, W_DROP, W_HDR} wState_t;
  typedef enum logic [2:0] {R_IDLE, R_HDR, R_HDRW, R_LEN, R_LENW, R_DATA, R_EMIT} rState_t;

  wState_t wState, wNext;
  rState_t rState, rNext;
  logic accept;

  always_comb begin
    str = '0;
    wNext = wState;
    pktRejected = 1'b0;
    inReady = (wState != W_HDR) && !closeReq && !clearReq;
    accept = inValid && inReady;
    case (wState)
      W_IDLE: begin
        if (closeReq && !clearReq) begin
          str.closeWr = 1'b1;
        end else if (accept && inFirst) begin
          if (st.tableFull || st.commitAtEnd) begin
            pktRejected = 1'b1;
            str.setFull = 1'b1;
            wNext = inLast ? W_IDLE : W_DROP;
          end else begin
            str.startPkt = 1'b1;
            str.takeByte = 1'b1;
            if (inLast) begin
              if (ONE_OK) wNext = W_HDR;
              else pktRejected = 1'b1;
            end else begin
              wNext = W_PKT;
            end
          end
        end
      end
      W_PKT: begin
        if (accept) begin
          if (st.wrAtEnd) begin
            pktRejected = 1'b1;
            str.setFull = 1'b1;
            wNext = inLast ? W_IDLE : W_DROP;
          end else begin
            str.takeByte = 1'b1;
            if (inLast) begin
              if (st.lenOk) begin
                wNext = W_HDR;
              end else begin
                pktRejected = 1'b1;
                wNext = W_IDLE;
              end
            end
          end
        end
      end
      W_DROP: if (accept && inLast) wNext = W_IDLE;
      default: begin
        str.commitLen = 1'b1;
        wNext = W_IDLE;
      end
    endcase
    if (clearReq) begin
      str.clr = 1'b1;
      wNext = W_IDLE;
    end

    rNext = rState;
    case (rState)
      R_IDLE: if (rdStart) rNext = R_HDR;
      R_HDR: begin
        str.rdHdr = 1'b1;
        rNext = R_HDRW;
      end
      R_HDRW: begin
        str.loadHdr = 1'b1;
        rNext = st.rdHdrZero ? R_IDLE : R_LEN;
      end
      R_LEN: begin
        str.rdLen = 1'b1;
        rNext = R_LENW;
      end
      R_LENW: begin
        str.loadLen = 1'b1;
        rNext = R_DATA;
      end
      R_DATA: begin
        str.rdWord = 1'b1;
        rNext = R_EMIT;
      end
      default: begin
        str.emit = 1'b1;
        if (st.rdWordEnd) begin
          if (!st.rdPktEnd) rNext = R_DATA;
          else rNext = st.rdAllDone ? R_IDLE : R_LEN;
        end
      end
    endcase
  end

  assign rdBusy = (rState != R_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wState <= W_IDLE;
      rState <= R_IDLE;
    end else begin
      wState <= wNext;
      rState <= rNext;
    end
  end

  AST_ONE_RAM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.takeByte, str.commitLen, str.closeWr})); // R2
  AST_HDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (wState == W_HDR) |=> (wState != W_HDR)); // R8
  AST_EMIT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    str.emit |-> $past(rState != R_IDLE)); // R10

endmodule

// File: rtl/pkt_container_dp.sv
module pkt_container_dp
  import pkt_container_pkg::*;
#(
  parameter int WORDS     = 1024,
  parameter int HDR_WORDS = 34,
  parameter int MAX_PKTS  = 66,
  parameter int MIN_LEN   = 64,
  parameter int MAX_LEN   = 1538
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t str,
  input  logic [7:0]   inByte,
  input  logic         inLast,
  output dpStatus_t    st,
  output logic         containerFull,
  output logic [7:0]   outByte,
  output logic         outFirst,
  output logic         outLast,
  output logic [15:0]  hdrWords,
  output logic [15:0]  hdrPkts
);

  localparam int AW = $clog2(WORDS);
  localparam int PW = AW + 1;
  localparam int CW = $clog2(MAX_PKTS + 1);

  logic [31:0]   mem [WORDS];
  logic [31:0]   ramRd;
  logic [PW-1:0] wrPtr, commitPtr, curPtr, rdPtr;
  logic [1:0]    lane, curLane, rdLane;
  logic [31:0]   wordBuf, curBuf, newBuf;
  logic [15:0]   pktLen, curLen, lenHold, remain, rdIdx;
  logic [31:0]   lenPlus;
  logic [CW-1:0] pktCount;
  logic          full, rdFirst, flush;
  logic          memWe, memRe;
  logic [AW-1:0] memWa, memRa;
  logic [31:0]   memWd;

  // effective write state: a new packet starts from the commit point
  assign curPtr  = str.startPkt ? commitPtr : wrPtr;
  assign curLane = str.startPkt ? 2'd0 : lane;
  assign curBuf  = str.startPkt ? 32'd0 : wordBuf;
  assign curLen  = str.startPkt ? 16'd0 : pktLen;
  assign newBuf  = curBuf | ({24'd0, inByte} << {curLane, 3'b000});
  assign flush   = str.takeByte && ((curLane == 2'd3) || inLast);
  assign lenPlus = 32'(pktLen) + 32'd1;

  always_comb begin
    memWe = 1'b0;
    memWa = '0;
    memWd = '0;
    if (str.commitLen) begin
      memWe = 1'b1;
      memWa = AW'(pktCount >> 1) + AW'(1);
      memWd = pktCount[0] ? {lenHold, pktLen} : {pktLen, 16'd0};
    end else if (str.closeWr) begin
      memWe = 1'b1;
      memWd = {16'(commitPtr), 16'(pktCount)};
    end else if (flush) begin
      memWe = 1'b1;
      memWa = curPtr[AW-1:0];
      memWd = newBuf;
    end
  end

  assign memRe = str.rdHdr | str.rdLen | str.rdWord;
  always_comb begin
    if (str.rdHdr)     memRa = '0;
    else if (str.rdLen) memRa = AW'(rdIdx >> 1) + AW'(1);
    else               memRa = rdPtr[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (memWe) mem[memWa] <= memWd;
    if (memRe) ramRd <= mem[memRa];
  end

  // fill side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= PW'(HDR_WORDS);
      commitPtr <= PW'(HDR_WORDS);
      lane      <= '0;
      wordBuf   <= '0;
      pktLen    <= '0;
      lenHold   <= '0;
      pktCount  <= '0;
      full      <= 1'b0;
    end else if (str.clr) begin
      wrPtr     <= PW'(HDR_WORDS);
      commitPtr <= PW'(HDR_WORDS);
      lane      <= '0;
      wordBuf   <= '0;
      pktLen    <= '0;
      pktCount  <= '0;
      full      <= 1'b0;
    end else begin
      if (str.takeByte) begin
        pktLen <= curLen + 16'd1;
        if (flush) begin
          wrPtr   <= curPtr + PW'(1);
          lane    <= 2'd0;
          wordBuf <= '0;
        end else begin
          wrPtr   <= curPtr;
          lane    <= curLane + 2'd1;
          wordBuf <= newBuf;
        end
      end
      if (str.commitLen) begin
        if (!pktCount[0]) lenHold <= pktLen;
        pktCount  <= pktCount + CW'(1);
        commitPtr <= wrPtr;
      end
      if (str.setFull) full <= 1'b1;
    end
  end

  // drain side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrWords <= '0;
      hdrPkts  <= '0;
      rdIdx    <= '0;
      rdPtr    <= PW'(HDR_WORDS);
      remain   <= '0;
      rdLane   <= '0;
      rdFirst  <= 1'b0;
    end else begin
      if (str.loadHdr) begin
        hdrWords <= ramRd[31:16];
        hdrPkts  <= ramRd[15:0];
        rdIdx    <= '0;
        rdPtr    <= PW'(HDR_WORDS);
      end
      if (str.loadLen) begin
        remain  <= rdIdx[0] ? ramRd[15:0] : ramRd[31:16];
        rdLane  <= 2'd0;
        rdFirst <= 1'b1;
      end
      if (str.emit) begin
        rdFirst <= 1'b0;
        remain  <= remain - 16'd1;
        if (st.rdWordEnd) begin
          rdLane <= 2'd0;
          rdPtr  <= rdPtr + PW'(1);
        end else begin
          rdLane <= rdLane + 2'd1;
        end
        if (remain == 16'd1) rdIdx <= rdIdx + 16'd1;
      end
    end
  end

  assign st.commitAtEnd = (commitPtr == PW'(WORDS));
  assign st.wrAtEnd     = (lane == 2'd0) && (wrPtr == PW'(WORDS));
  assign st.tableFull   = (pktCount == CW'(MAX_PKTS));
  assign st.lenOk       = (lenPlus >= 32'(MIN_LEN)) && (lenPlus <= 32'(MAX_LEN));
  assign st.rdWordEnd   = (rdLane == 2'd3) || (remain == 16'd1);
  assign st.rdPktEnd    = (remain == 16'd1);
  assign st.rdAllDone   = ((rdIdx + 16'd1) == hdrPkts);
  assign st.rdHdrZero   = (ramRd[15:0] == 16'd0);

  assign containerFull = full;
  assign outByte  = ramRd[{rdLane, 3'b000} +: 8];
  assign outFirst = str.emit && rdFirst;
  assign outLast  = str.emit && (remain == 16'd1);

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr <= PW'(WORDS)) && (commitPtr <= PW'(WORDS))); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pktCount <= CW'(MAX_PKTS)); // R6
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (full && !str.clr) |=> full); // R6
  AST_COMMIT_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    str.commitLen |-> ((pktLen >= 16'(MIN_LEN)) && (pktLen <= 16'(MAX_LEN)))); // R5
  AST_COMMIT_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (str.commitLen && !str.clr) |=> (pktCount == $past(pktCount) + CW'(1))); // R3

endmodule

// File: rtl/pkt_container.sv
module pkt_container
  import pkt_container_pkg::*;
#(
  parameter int WORDS    = 1024,
  parameter int MAX_PKTS = 66,
  parameter int MIN_LEN  = 64,
  parameter int MAX_LEN  = 1538
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clearReq,
  input  logic        closeReq,
  input  logic        inValid,
  input  logic [7:0]  inByte,
  input  logic        inFirst,
  input  logic        inLast,
  output logic        inReady,
  output logic        pktRejected,
  output logic        containerFull,
  input  logic        rdStart,
  output logic        rdBusy,
  output logic        outValid,
  output logic [7:0]  outByte,
  output logic        outFirst,
  output logic        outLast,
  output logic [15:0] hdrWords,
  output logic [15:0] hdrPkts
);

  localparam int HDR_WORDS = 1 + (MAX_PKTS + 1) / 2;

  ctrlStrobes_t str;
  dpStatus_t    st;

  pkt_container_ctrl #(
    .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .clearReq(clearReq), .closeReq(closeReq),
    .inValid(inValid), .inFirst(inFirst), .inLast(inLast), .rdStart(rdStart),
    .st(st), .str(str), .inReady(inReady), .pktRejected(pktRejected),
    .rdBusy(rdBusy)
  );

  pkt_container_dp #(
    .WORDS(WORDS), .HDR_WORDS(HDR_WORDS), .MAX_PKTS(MAX_PKTS),
    .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .inByte(inByte), .inLast(inLast),
    .st(st), .containerFull(containerFull), .outByte(outByte),
    .outFirst(outFirst), .outLast(outLast), .hdrWords(hdrWords),
    .hdrPkts(hdrPkts)
  );

  assign outValid = str.emit;

endmodule

// File: tb/tb_pkt_container.sv
`timescale 1ns/1ps
module tb_pkt_container;

  localparam int WORDS = 32;
  localparam int MAXP  = 6;
  localparam int HDR   = 1 + (MAXP + 1) / 2;
  localparam int MINL  = 4;
  localparam int MAXL  = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearReq = 1'b0, closeReq = 1'b0, inValid = 1'b0, inFirst = 1'b0, inLast = 1'b0;
  logic rdStart = 1'b0;
  logic [7:0] inByte = 8'd0;
  logic inReady, pktRejected, containerFull, rdBusy, outValid, outFirst, outLast;
  logic [7:0] outByte;
  logic [15:0] hdrWords, hdrPkts;

  always #2.5 clk = ~clk;

  pkt_container #(.WORDS(WORDS), .MAX_PKTS(MAXP), .MIN_LEN(MINL), .MAX_LEN(MAXL)) dut (
    .clk(clk), .rstN(rstN), .clearReq(clearReq), .closeReq(closeReq),
    .inValid(inValid), .inByte(inByte), .inFirst(inFirst), .inLast(inLast),
    .inReady(inReady), .pktRejected(pktRejected), .containerFull(containerFull),
    .rdStart(rdStart), .rdBusy(rdBusy), .outValid(outValid), .outByte(outByte),
    .outFirst(outFirst), .outLast(outLast), .hdrWords(hdrWords), .hdrPkts(hdrPkts)
  );

  int nChecks = 0, nFail = 0;
  int mCommit, mCount;
  bit mFull;
  int expLen [MAXP];
  int expSeed [MAXP];
  logic [7:0] rxByte [512];
  bit rxFirst [512];
  bit rxLast [512];
  int rxN;

  function automatic logic [7:0] pb(int seed, int i);
    return 8'((seed * 13) + (i * 7) + 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearBox();
    @(negedge clk); clearReq = 1'b1;
    @(negedge clk); clearReq = 1'b0;
    mCommit = HDR; mCount = 0; mFull = 1'b0;
    #1 check(containerFull == 1'b0, "R9 full cleared", int'(containerFull), 0);
  endtask

  task automatic sendPkt(int len, int seed, bit gaps);
    int words, rej;
    bit acc, fullCause;
    string tag;
    words = (len + 3) / 4;
    rej = 0;
    fullCause = (mCount >= MAXP) || (mCommit + words > WORDS);
    acc = !fullCause && (len >= MINL) && (len <= MAXL);
    if (mCount >= MAXP) tag = "R6";
    else if (mCommit + words > WORDS) tag = "R7";
    else if (!acc) tag = "R5";
    else tag = "R2";
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk); inValid = 1'b0;
      end
      forever begin
        @(negedge clk);
        inValid = 1'b1; inByte = pb(seed, i);
        inFirst = (i == 0); inLast = (i == len - 1);
        #1;
        if (inReady) begin
          if (pktRejected) rej++;
          break;
        end
      end
    end
    @(negedge clk);
    inValid = 1'b0; inFirst = 1'b0; inLast = 1'b0;
    #1 check(inReady == !acc, "R8 ready after packet", int'(inReady), int'(!acc));
    @(negedge clk);
    #1 check(inReady == 1'b1, "R8 ready restored", int'(inReady), 1);
    check(rej == (acc ? 0 : 1), {tag, " reject pulse"}, rej, acc ? 0 : 1);
    if (fullCause) mFull = 1'b1;
    check(containerFull == mFull, {tag, " full flag"}, int'(containerFull), int'(mFull));
    if (acc) begin
      expLen[mCount] = len; expSeed[mCount] = seed;
      mCount++; mCommit += words;
    end
  endtask

  task automatic closeAndRead(string ctx);
    int pos, bad, wd;
    @(negedge clk); closeReq = 1'b1;
    @(negedge clk); closeReq = 1'b0; rdStart = 1'b1;
    @(negedge clk); rdStart = 1'b0;
    rxN = 0; wd = 0;
    #1;
    while (rdBusy && wd < 4000) begin
      if (outValid && rxN < 512) begin
        rxByte[rxN] = outByte; rxFirst[rxN] = outFirst; rxLast[rxN] = outLast; rxN++;
      end
      @(negedge clk); #1; wd++;
    end
    check(!rdBusy, {"R10 reader finished ", ctx}, int'(rdBusy), 0);
    check(hdrPkts == 16'(mCount), {"R4 packet count ", ctx}, int'(hdrPkts), mCount);
    check(hdrWords == 16'(mCommit), {"R4 word count ", ctx}, int'(hdrWords), mCommit);
    pos = 0;
    for (int p = 0; p < mCount; p++) begin
      bad = 0;
      for (int i = 0; i < expLen[p]; i++) begin
        if (pos + i >= rxN) bad++;
        else if (rxByte[pos + i] !== pb(expSeed[p], i)) bad++;
      end
      check(bad == 0, {"R2 packet bytes ", ctx}, bad, 0);
      bad = 0;
      if (pos + expLen[p] - 1 >= rxN) bad++;
      else begin
        if (!rxFirst[pos]) bad++;
        if (!rxLast[pos + expLen[p] - 1]) bad++;
        for (int i = 1; i < expLen[p] - 1; i++)
          if (rxFirst[pos + i] || rxLast[pos + i]) bad++;
      end
      check(bad == 0, {"R3 length markers ", ctx}, bad, 0);
      pos += expLen[p];
    end
    check(rxN == pos, {"R10 total bytes ", ctx}, rxN, pos);
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    mCommit = HDR; mCount = 0; mFull = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(inReady == 1'b1, "R1 reset ready", int'(inReady), 1);
    check(containerFull == 1'b0, "R1 reset full", int'(containerFull), 0);
    check(rdBusy == 1'b0 && outValid == 1'b0, "R1 reset reader idle", int'(rdBusy), 0);
    closeAndRead("R1 empty");

    // sweep every length, legal and not, against table and word limits
    for (int r = 0; r < 17; r++) begin
      clearBox();
      for (int k = 0; k < 7; k++) begin
        int len;
        len = MINL + ((r + 5 * k) % (MAXL - MINL + 1));
        if ((r + k) % 7 == 3) len = (r % 2 == 1) ? MINL - 1 : MAXL + 1;
        if (r == 5 && k == 2) len = 1;
        sendPkt(len, r * 8 + k, (r % 2 == 1));
      end
      closeAndRead("sweep");
    end

    // exact fill to the last word, then table limit
    clearBox();
    for (int k = 0; k < 5; k++) sendPkt(MAXL, 200 + k, 1'b0);
    sendPkt(12, 210, 1'b0);
    check(mCommit == WORDS, "R7 exact fill model", mCommit, WORDS);
    sendPkt(MINL, 211, 1'b0);
    closeAndRead("R7 exact fill");

    // word limit with table room left
    clearBox();
    for (int k = 0; k < 5; k++) sendPkt(MAXL, 220 + k, 1'b1);
    sendPkt(16, 230, 1'b0);
    sendPkt(MINL + 5, 231, 1'b0);
    closeAndRead("R7 overflow");

    // clear after a full container
    clearBox();
    closeAndRead("R9 after clear");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule